// File: doc/BRIEF.md
# UTMI Packet Transmit Sequencer

This block is the transmit half of a USB serial interface engine, facing the 8-bit bidirectional data path of a UTMI transceiver. Upstream logic writes a packet into a small byte buffer and then asks for it to be sent, giving a byte count. The sequencer raises TxValid with the first byte (the PID) already on the data bus. It then steps through the buffer one byte per accepted transfer, and drops TxValid once the final byte has been taken.

Everything runs on the 60 MHz clock that the transceiver supplies. A byte counts as taken on every rising edge where TxValid and TxReady are both high. Acceptance is level-based, not edge-based: if TxReady stays high on two edges in a row, two bytes have gone out, and the following byte must already be on the bus in the second cycle. Holding the old byte there would make the transceiver send it twice. In full speed TxReady may stay low for long stretches, and the current byte then stays on the bus.

Upstream sees a busy level for the length of the packet and a one-cycle done pulse when it ends.

Top module: `utmiTxSeq`

## Requirements
- R1: After a synchronous reset, and whenever no packet is in progress, txValid is 0 and dataOut is 0x00. busy and done are both 0 right after reset.
- R2: startReq sampled high while idle, with startLen in 1..64, makes txValid go high on the next clock edge. In that same cycle dataOut carries buffer byte 0, the PID.
- R3: On each edge where txValid is high and txReady is low, txValid and dataOut keep their values for the following cycle.
- R4: On each edge where txValid and txReady are both high and bytes remain, dataOut shows the next buffer byte from the following cycle. Buffer addresses run upward from 0 in packet order. txReady held high on consecutive edges advances one byte per edge.
- R5: The edge that accepts byte number startLen-1 causes three things in the next cycle: txValid falls, dataOut returns to 0x00, and done is high for exactly that one cycle.
- R6: busy equals txValid. While busy, startReq and startLen are ignored, so the length latched at the start of the packet governs it.
- R7: A start request with startLen of 0 or above 64 is ignored, and txValid stays low.
- R8: A buffer write (bufWrEn, byte address bufWrAddr, data bufWrData) takes effect only while busy is low. Writes during a packet are dropped.
- R9: A start request accepted in the done cycle begins a new packet on the next edge, with no idle cycle between the two packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz clock from the transceiver |
| rst | input | 1 | Synchronous reset, active high |
| bufWrEn | input | 1 | Write strobe for the packet buffer |
| bufWrAddr | input | 6 | Byte address of the buffer write |
| bufWrData | input | 8 | Byte to write |
| startReq | input | 1 | Request to transmit a packet |
| startLen | input | 7 | Packet length in bytes (1..64) |
| txReady | input | 1 | Transceiver accepts the byte on this edge |
| txValid | output | 1 | Packet transmission in progress |
| dataOut | output | 8 | Byte presented to the transceiver |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle end-of-packet pulse |

## Verification
All outputs are registered, so each result falls due exactly one edge after its cause. txValid and the PID follow the edge that samples startReq. Each next byte follows the edge that samples txReady high. The fall of txValid and the done pulse follow the edge that accepts the last byte. The bench drives inputs on falling edges. On every rising edge a behavioural model, built from a byte array and counters, advances. At each falling edge the outputs are compared with that model. The txReady patterns cover always-high, sparse stalls and pseudo-random gaps, so both long holds and back-to-back acceptances are checked at the cycle where they take effect.

// File: rtl/txSeqPkg.sv
package txSeqPkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_SEND = 1'b1
  } seqState_t;

  // Strobes from the control to the datapath, at most one high per cycle.
  typedef struct packed {
    logic loadFirst;   // present byte 0 and aim the pointer at byte 1
    logic stepNext;    // present the byte under the pointer and advance
    logic endPkt;      // clear the data bus at end of packet
  } seqStrobe_t;

endpackage

// File: rtl/txSeqCtrl.sv
module txSeqCtrl
  import txSeqPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic [LEN_W-1:0] startLen,
  input  logic             txReady,
  output seqStrobe_t       strobe,
  output logic             txValid,
  output logic             busy,
  output logic             done
);

  seqState_t        state;
  logic [LEN_W-1:0] bytesLeft;
  logic             lenOk;
  logic             startOk;
  logic             accept;
  logic             lastByte;

  assign lenOk    = (startLen != '0) && (startLen <= LEN_W'(DEPTH));
  assign startOk  = (state == SEQ_IDLE) && startReq && lenOk;
  assign accept   = (state == SEQ_SEND) && txReady;
  assign lastByte = (bytesLeft == LEN_W'(1));

  always_comb begin
    strobe           = '0;
    strobe.loadFirst = startOk;
    strobe.stepNext  = accept && !lastByte;
    strobe.endPkt    = accept && lastByte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      bytesLeft <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (startOk) begin
            state     <= SEQ_SEND;
            bytesLeft <= startLen;
          end
        end
        SEQ_SEND: begin
          if (accept) begin
            if (lastByte) begin
              state     <= SEQ_IDLE;
              bytesLeft <= '0;
              done      <= 1'b1;
            end else begin
              bytesLeft <= bytesLeft - LEN_W'(1);
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign txValid = (state == SEQ_SEND);
  assign busy    = txValid;

endmodule

// File: rtl/txSeqData.sv
module txSeqData
  import txSeqPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrAllow,
  input  logic              bufWrEn,
  input  logic [ADDR_W-1:0] bufWrAddr,
  input  logic [DATA_W-1:0] bufWrData,
  input  seqStrobe_t        strobe,
  output logic [DATA_W-1:0] dataOut
);

  logic [DATA_W-1:0] byteBuf [DEPTH];
  logic [ADDR_W-1:0] readPtr;

  // One write decoder per buffer entry; writes are locked out mid-packet.
  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    logic hit;
    assign hit = bufWrEn && wrAllow && (bufWrAddr == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (hit) byteBuf[g] <= bufWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut <= '0;
      readPtr <= '0;
    end else if (strobe.loadFirst) begin
      dataOut <= byteBuf[0];
      readPtr <= ADDR_W'(1);
    end else if (strobe.stepNext) begin
      dataOut <= byteBuf[readPtr];
      readPtr <= readPtr + ADDR_W'(1);
    end else if (strobe.endPkt) begin
      dataOut <= '0;
      readPtr <= '0;
    end
  end

endmodule

// File: rtl/utmiTxSeq.sv
module utmiTxSeq
  import txSeqPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bufWrEn,
  input  logic [ADDR_W-1:0] bufWrAddr,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              startReq,
  input  logic [LEN_W-1:0]  startLen,
  input  logic              txReady,
  output logic              txValid,
  output logic [DATA_W-1:0] dataOut,
  output logic              busy,
  output logic              done
);

  seqStrobe_t strobe;

  txSeqCtrl #(
    .DEPTH (DEPTH),
    .LEN_W (LEN_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .startLen (startLen),
    .txReady  (txReady),
    .strobe   (strobe),
    .txValid  (txValid),
    .busy     (busy),
    .done     (done)
  );

  txSeqData #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_data (
    .clk       (clk),
    .rst       (rst),
    .wrAllow   (!busy),
    .bufWrEn   (bufWrEn),
    .bufWrAddr (bufWrAddr),
    .bufWrData (bufWrData),
    .strobe    (strobe),
    .dataOut   (dataOut)
  );

endmodule

// File: rtl/utmiTxSeqChk.sv
module utmiTxSeqChk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int LEN_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              startReq,
  input logic [LEN_W-1:0]  startLen,
  input logic              txReady,
  input logic              txValid,
  input logic [DATA_W-1:0] dataOut,
  input logic              busy,
  input logic              done
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !txValid |-> dataOut == '0);

  p_start_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(txValid) |-> $past(startReq) && ($past(startLen) != '0)
                       && ($past(startLen) <= LEN_W'(DEPTH)));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    txValid && !txReady |=> txValid && $stable(dataOut));

  p_end_clean_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !txValid && $past(txValid) && $past(txReady));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_window_r6: assert property (@(posedge clk) disable iff (rst)
    busy == txValid);

endmodule

bind utmiTxSeq utmiTxSeqChk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .LEN_W  (LEN_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .startReq (startReq),
  .startLen (startLen),
  .txReady  (txReady),
  .txValid  (txValid),
  .dataOut  (dataOut),
  .busy     (busy),
  .done     (done)
);

// File: tb/utmiTxSeq_bench.sv
module utmiTxSeq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bufWrEn = 1'b0;
  logic [5:0] bufWrAddr = '0;
  logic [7:0] bufWrData = '0;
  logic       startReq = 1'b0;
  logic [6:0] startLen = '0;
  logic       txReady = 1'b0;
  logic       txValid;
  logic [7:0] dataOut;
  logic       busy;
  logic       done;

  always #4 clk = ~clk;

  utmiTxSeq u_utmiTxSeq (
    .clk(clk), .rst(rst), .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr),
    .bufWrData(bufWrData), .startReq(startReq), .startLen(startLen),
    .txReady(txReady), .txValid(txValid), .dataOut(dataOut),
    .busy(busy), .done(done)
  );

  // Behavioural reference model
  int    mMem [64];
  bit    mValid, mDone;
  int    mOut, mLen, mIdx;
  string evTag = "R1";
  string curReq = "R1";
  int    checks = 0, fails = 0, cycles = 0;
  bit    checkOn = 0;
  int    lfsr = 32'h1d3a;

  always @(posedge clk) begin
    bit wasValid;
    wasValid = mValid;
    cycles++;
    if (rst) begin
      mValid = 0; mDone = 0; mOut = 0; mLen = 0; mIdx = 0; evTag = "R1";
    end else begin
      mDone = 0;
      if (!mValid) begin
        evTag = "R1";
        if (startReq && startLen >= 1 && startLen <= 64) begin
          mValid = 1; mLen = startLen; mIdx = 0; mOut = mMem[0]; evTag = "R2";
        end
      end else if (txReady) begin
        if (mIdx == mLen - 1) begin
          mValid = 0; mOut = 0; mDone = 1; evTag = "R5";
        end else begin
          mIdx++; mOut = mMem[mIdx]; evTag = "R4";
        end
      end else begin
        evTag = "R3";
      end
      if (bufWrEn && !wasValid) mMem[bufWrAddr] = bufWrData;
    end
  end

  always @(negedge clk) begin
    if (checkOn) begin
      checks++;
      if (txValid !== mValid || dataOut !== mOut[7:0] || busy !== mValid || done !== mDone) begin
        fails++;
        $display("FAIL %s (scenario %s): txValid=%0b dataOut=%02h busy=%0b done=%0b expected txValid=%0b dataOut=%02h busy=%0b done=%0b",
                 evTag, curReq, txValid, dataOut, busy, done, mValid, mOut[7:0], mValid, mDone);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic fillBuf(input int seed);
    for (int i = 0; i < 64; i++) begin
      bufWrEn = 1; bufWrAddr = 6'(i); bufWrData = 8'(((i * 7 + seed) ^ 8'hA5) & 8'hFF);
      tick();
    end
    bufWrEn = 0;
  endtask

  // mode 0: txReady always high, 1: high every fourth cycle, 2: pseudo-random
  task automatic runPkt(input int len, input int mode, input bit meddle);
    int cyc;
    startReq = 1; startLen = 7'(len);
    tick();
    startReq = 0; startLen = 0;
    cyc = 0;
    while (mValid && cyc < 2000) begin
      case (mode)
        0: txReady = 1;
        1: txReady = (cyc % 4 == 3);
        default: begin
          lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
          txReady = lfsr[0] | lfsr[3];
        end
      endcase
      if (meddle && cyc == 1) begin
        startReq = 1; startLen = 7'd2;                      // R6: ignored
        bufWrEn = 1; bufWrAddr = 6'd1; bufWrData = 8'h3C;   // R8: dropped
      end
      tick();
      startReq = 0; startLen = 0; bufWrEn = 0;
      cyc++;
    end
    txReady = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    // R1: reset state, checked directly
    checks++;
    if (txValid !== 0 || dataOut !== 8'h00 || busy !== 0 || done !== 0) begin
      fails++;
      $display("FAIL R1: txValid=%0b dataOut=%02h busy=%0b done=%0b expected 0 00 0 0",
               txValid, dataOut, busy, done);
    end
    checkOn = 1;
    curReq = "R8"; fillBuf(3);
    curReq = "R2"; runPkt(1, 0, 0); repeat (2) tick();
    curReq = "R4"; runPkt(5, 0, 0); repeat (2) tick();
    curReq = "R3"; runPkt(6, 1, 0); repeat (2) tick();
    curReq = "R4"; runPkt(64, 2, 0); repeat (2) tick();
    curReq = "R6"; runPkt(4, 1, 1); repeat (2) tick();
    curReq = "R8"; runPkt(3, 0, 0); repeat (2) tick();
    curReq = "R7"; runPkt(0, 0, 0); repeat (2) tick();
    runPkt(65, 0, 0); repeat (2) tick();
    runPkt(127, 0, 0); repeat (2) tick();
    curReq = "R8"; fillBuf(91);
    curReq = "R9"; runPkt(3, 2, 0); runPkt(2, 0, 0); runPkt(7, 1, 0); repeat (3) tick();
    curReq = "R5"; runPkt(64, 0, 0); repeat (3) tick();
    checkOn = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: run still going, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule